// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control core of a multi-channel successive-approximation converter. It runs two programmable lists of channel slots. The regular list has up to sixteen slots and suits background scanning. The injected list has up to four slots and serves urgent measurements. For every conversion it drives a channel select, a sample-phase strobe and a convert-phase strobe. At the end of the convert phase it captures the converter's 12-bit result and places it, aligned, into a result register.

An injected request preempts regular work. The regular conversion in progress is dropped, the whole injected list runs, and then the regular scan picks up again at the slot that was interrupted. All results of the regular list share one data register. Each injected slot owns its own data register. Two completion flags, each with an interrupt enable, report finished work. All configuration arrives on plain input ports.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, `ch_sel`, `smp_phase`, `cnv_phase`, `reg_data`, `inj_data`, both completion flags and both interrupt outputs are all zero.
- R2: A rising edge of `conv_enable` starts the regular list. While `conv_enable` is low, any conversion in progress is abandoned, both strobes are low from the next cycle on, and triggers are ignored.
- R3: `reg_trig_mode` sets which edge of `reg_trig` starts the regular list, and `inj_trig_mode` does the same for `inj_trig` and the injected list. The codes are 0 = never, 1 = rising, 2 = falling, 3 = both edges.
- R4: With `scan_mode` = 0, only slot 0 converts. With `scan_mode` = 1, slots 0 to `reg_len` convert in ascending order. Slot k names its channel in `reg_slot_ch[4k+3:4k]`.
- R5: With `cont_mode` = 1, the regular list wraps from its last slot back to slot 0 without stopping. With `cont_mode` = 0, the block goes idle after the last slot.
- R6: Each conversion holds `smp_phase` high for exactly 3 << code cycles and then holds `cnv_phase` high for exactly 12 cycles. The code is `smp_code[3c+2:3c]` for channel c. `ch_sel` changes only when a sample phase begins.
- R7: When `inj_len` = 3, the injected slots convert in the order 0, 1, 2, 3. Otherwise `inj_len`+1 conversions run, starting at slot 3 and moving downward. Injected slot s names its channel in `inj_slot_ch[4s+3:4s]`.
- R8: An injected start during a regular conversion abandons that conversion. After the injected list finishes, the interrupted slot is converted again and the scan continues. An injected trigger that arrives while the injected list is running is ignored.
- R9: With `align_left` = 0, a result is stored as {4'b0, result}. With `align_left` = 1, it is stored as {result, 4'b0}.
- R10: A regular result overwrites `reg_data` one cycle after the last convert cycle. An injected result from slot s goes to `inj_data[16s+15:16s]`.
- R11: `eoc_reg` is set after every regular conversion. `eoc_inj` is set after the last conversion of the injected list. Each flag is cleared by its clear input, and a set in the same cycle wins. `irq_reg` and `irq_inj` are each flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_enable | input | 1 | Run enable; a rising edge starts the regular list |
| scan_mode | input | 1 | 1 = walk all regular slots, 0 = slot 0 only |
| cont_mode | input | 1 | 1 = wrap the regular list |
| align_left | input | 1 | Result alignment select |
| reg_slot_ch | input | 64 | Channel for each regular slot, 4 bits per slot |
| reg_len | input | 4 | Index of the last regular slot |
| inj_slot_ch | input | 16 | Channel for each injected slot, 4 bits per slot |
| inj_len | input | 2 | Injected conversion count minus one |
| smp_code | input | 48 | 3-bit sample-length code per channel |
| reg_trig | input | 1 | Regular trigger line |
| reg_trig_mode | input | 2 | Edge selection for `reg_trig` |
| inj_trig | input | 1 | Injected trigger line |
| inj_trig_mode | input | 2 | Edge selection for `inj_trig` |
| adc_result | input | 12 | Converter result, valid in the last convert cycle |
| clr_eoc_reg | input | 1 | Clears `eoc_reg` |
| clr_eoc_inj | input | 1 | Clears `eoc_inj` |
| irq_reg_en | input | 1 | Interrupt enable for regular completion |
| irq_inj_en | input | 1 | Interrupt enable for injected completion |
| ch_sel | output | 4 | Channel being converted |
| smp_phase | output | 1 | Sample window strobe |
| cnv_phase | output | 1 | Convert window strobe |
| reg_data | output | 16 | Regular result register |
| inj_data | output | 64 | Injected result registers, 16 bits per slot |
| eoc_reg | output | 1 | Regular conversion done flag |
| eoc_inj | output | 1 | Injected list done flag |
| irq_reg | output | 1 | Regular interrupt |
| irq_inj | output | 1 | Injected interrupt |

## Verification
The hardest case to reach is preemption in the middle of a regular scan. The injected trigger must land while a particular regular slot is in its sample phase, so that slot is abandoned and must later be rerun. The stimulus starts a three-slot scan and watches `ch_sel` and `smp_phase` until the second slot is sampling. Only then does it raise the injected trigger. The scoreboard, which was loaded beforehand with the order regular slot 0, injected slot 3, regular slots 1 and 2, then shows whether the scan resumed at the right place. A second injected edge raised during a running injected list must add no conversion, and a pop from an empty scoreboard shows it if one appears.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   localparam int unsigned CONV_CYCLES = 12;
   localparam int unsigned SMP_CODE_W  = 3;
   localparam int unsigned TMR_W       = 10;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_BOTH = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      GRP_IDLE = 2'd0,
      GRP_REG  = 2'd1,
      GRP_INJ  = 2'd2
   } grp_e;

   // sample length in cycles for a 3-bit code: 3, 6, 12, ... 384
   function automatic logic [TMR_W-1:0] smp_cycles(input logic [SMP_CODE_W-1:0] code);
      return 10'd3 << code;
   endfunction
endpackage

// File: rtl/adcseq_edge_sel.sv
module adcseq_edge_sel
   import adcseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sig,
   input  logic [1:0] mode,
   output logic       hit
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig;
   end

   always_comb begin
      unique case (mode)
         TRIG_RISE: hit = sig & ~sig_q;
         TRIG_FALL: hit = ~sig & sig_q;
         TRIG_BOTH: hit = sig ^ sig_q;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/adcseq_phase_timer.sv
module adcseq_phase_timer #(
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned CONV_LEN = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [CNT_W-1:0] smp_len,
   output logic             smp_phase,
   output logic             cnv_phase,
   output logic             last
);
   logic             busy_q, in_smp_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         in_smp_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         in_smp_q <= 1'b1;
         cnt_q    <= smp_len - 1'b1;
      end else if (abort) begin
         busy_q   <= 1'b0;
         in_smp_q <= 1'b0;
      end else if (busy_q) begin
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (in_smp_q) begin
            in_smp_q <= 1'b0;
            cnt_q    <= CNT_W'(CONV_LEN - 1);
         end else begin
            busy_q <= 1'b0;
         end
      end
   end

   assign smp_phase = busy_q & in_smp_q;
   assign cnv_phase = busy_q & ~in_smp_q;
   assign last      = cnv_phase & (cnt_q == '0);
endmodule

// File: rtl/adcseq_align.sv
module adcseq_align #(
   parameter int unsigned RES_W  = 12,
   parameter int unsigned DATA_W = 16
) (
   input  logic [RES_W-1:0]  res,
   input  logic              left,
   output logic [DATA_W-1:0] word
);
   if (DATA_W < RES_W) begin : g_bad_width
      $error("adcseq_align: DATA_W must be at least RES_W");
   end else if (DATA_W == RES_W) begin : g_exact
      assign word = res;
   end else begin : g_pad
      localparam int unsigned PAD_W = DATA_W - RES_W;
      assign word = left ? {res, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, res};
   end
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
   import adcseq_pkg::*;
#(
   parameter int unsigned CH_W      = 4,
   parameter int unsigned REG_SLOTS = 16,
   parameter int unsigned INJ_SLOTS = 4,
   parameter int unsigned RES_W     = 12,
   parameter int unsigned DATA_W    = 16,
   localparam int unsigned NUM_CH   = 1 << CH_W,
   localparam int unsigned RLW      = $clog2(REG_SLOTS),
   localparam int unsigned ILW      = $clog2(INJ_SLOTS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         conv_enable,
   input  logic                         scan_mode,
   input  logic                         cont_mode,
   input  logic                         align_left,
   input  logic [REG_SLOTS*CH_W-1:0]    reg_slot_ch,
   input  logic [RLW-1:0]               reg_len,
   input  logic [INJ_SLOTS*CH_W-1:0]    inj_slot_ch,
   input  logic [ILW-1:0]               inj_len,
   input  logic [NUM_CH*SMP_CODE_W-1:0] smp_code,
   input  logic                         reg_trig,
   input  logic [1:0]                   reg_trig_mode,
   input  logic                         inj_trig,
   input  logic [1:0]                   inj_trig_mode,
   input  logic [RES_W-1:0]             adc_result,
   input  logic                         clr_eoc_reg,
   input  logic                         clr_eoc_inj,
   input  logic                         irq_reg_en,
   input  logic                         irq_inj_en,
   output logic [CH_W-1:0]              ch_sel,
   output logic                         smp_phase,
   output logic                         cnv_phase,
   output logic [DATA_W-1:0]            reg_data,
   output logic [INJ_SLOTS*DATA_W-1:0]  inj_data,
   output logic                         eoc_reg,
   output logic                         eoc_inj,
   output logic                         irq_reg,
   output logic                         irq_inj
);
   if (REG_SLOTS < 2 || (1 << RLW) != REG_SLOTS) begin : g_bad_reg
      $error("adc_conv_sequencer: REG_SLOTS must be a power of two >= 2");
   end
   if (INJ_SLOTS < 2 || (1 << ILW) != INJ_SLOTS) begin : g_bad_inj
      $error("adc_conv_sequencer: INJ_SLOTS must be a power of two >= 2");
   end

   // full injected list runs upward, a shorter one downward from the top slot
   function automatic logic [ILW-1:0] inj_order(input logic full, input logic [ILW-1:0] pos);
      return full ? pos : ~pos;
   endfunction

   grp_e             grp_q, grp_d;
   logic [RLW-1:0]   reg_idx_q, reg_idx_d, reg_last;
   logic             reg_run_q, reg_run_d;
   logic [ILW-1:0]   inj_pos_q, inj_pos_d, inj_slot_q, start_slot;
   logic [CH_W-1:0]  ch_q, start_ch;
   logic             en_q, reg_hit, inj_hit, reg_evt, inj_evt, inj_full;
   logic             tmr_start, tmr_abort, tmr_last;
   logic             store_reg, store_inj, set_eoc_reg, set_eoc_inj;
   logic             eoc_reg_q, eoc_inj_q;
   logic [DATA_W-1:0] res_word, reg_data_q;
   logic [TMR_W-1:0] smp_len;

   adcseq_edge_sel u_reg_edge (.clk(clk), .rst_n(rst_n), .sig(reg_trig),
                               .mode(reg_trig_mode), .hit(reg_hit));
   adcseq_edge_sel u_inj_edge (.clk(clk), .rst_n(rst_n), .sig(inj_trig),
                               .mode(inj_trig_mode), .hit(inj_hit));

   adcseq_phase_timer #(.CNT_W(TMR_W), .CONV_LEN(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .abort(tmr_abort),
      .smp_len(smp_len), .smp_phase(smp_phase), .cnv_phase(cnv_phase), .last(tmr_last));

   adcseq_align #(.RES_W(RES_W), .DATA_W(DATA_W)) u_align (
      .res(adc_result), .left(align_left), .word(res_word));

   assign reg_evt  = conv_enable & ((~en_q) | reg_hit) & ~reg_run_q;
   assign inj_evt  = conv_enable & inj_hit & (grp_q != GRP_INJ);
   assign inj_full = (inj_len == ILW'(INJ_SLOTS - 1));
   assign reg_last = scan_mode ? reg_len : '0;
   assign smp_len  = smp_cycles(smp_code[start_ch*SMP_CODE_W +: SMP_CODE_W]);

   always_comb begin
      grp_d       = grp_q;
      reg_idx_d   = reg_idx_q;
      reg_run_d   = reg_run_q;
      inj_pos_d   = inj_pos_q;
      tmr_start   = 1'b0;
      tmr_abort   = 1'b0;
      start_slot  = inj_slot_q;
      start_ch    = ch_q;
      store_reg   = 1'b0;
      store_inj   = 1'b0;
      set_eoc_reg = 1'b0;
      set_eoc_inj = 1'b0;
      if (!conv_enable) begin
         grp_d     = GRP_IDLE;
         reg_run_d = 1'b0;
         reg_idx_d = '0;
         tmr_abort = 1'b1;
      end else if (inj_evt) begin
         // preempt: a running regular slot is dropped and rerun later
         grp_d      = GRP_INJ;
         inj_pos_d  = '0;
         tmr_start  = 1'b1;
         start_slot = inj_order(inj_full, '0);
         start_ch   = inj_slot_ch[start_slot*CH_W +: CH_W];
         if (reg_evt) begin
            reg_run_d = 1'b1;
            reg_idx_d = '0;
         end
      end else if (tmr_last && grp_q == GRP_INJ) begin
         store_inj = 1'b1;
         if (inj_pos_q == inj_len) begin
            set_eoc_inj = 1'b1;
            if (reg_run_q) begin
               grp_d     = GRP_REG;
               tmr_start = 1'b1;
               start_ch  = reg_slot_ch[reg_idx_q*CH_W +: CH_W];
            end else begin
               grp_d = GRP_IDLE;
            end
         end else begin
            inj_pos_d  = inj_pos_q + 1'b1;
            tmr_start  = 1'b1;
            start_slot = inj_order(inj_full, inj_pos_q + 1'b1);
            start_ch   = inj_slot_ch[start_slot*CH_W +: CH_W];
         end
      end else if (tmr_last && grp_q == GRP_REG) begin
         store_reg   = 1'b1;
         set_eoc_reg = 1'b1;
         if (reg_idx_q >= reg_last) begin
            reg_idx_d = '0;
            if (cont_mode) begin
               tmr_start = 1'b1;
               start_ch  = reg_slot_ch[CH_W-1:0];
            end else begin
               reg_run_d = 1'b0;
               grp_d     = GRP_IDLE;
            end
         end else begin
            reg_idx_d = reg_idx_q + 1'b1;
            tmr_start = 1'b1;
            start_ch  = reg_slot_ch[(reg_idx_q + 1'b1)*CH_W +: CH_W];
         end
      end else if (reg_evt) begin
         reg_run_d = 1'b1;
         reg_idx_d = '0;
         if (grp_q == GRP_IDLE) begin
            grp_d     = GRP_REG;
            tmr_start = 1'b1;
            start_ch  = reg_slot_ch[CH_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q      <= GRP_IDLE;
         reg_idx_q  <= '0;
         reg_run_q  <= 1'b0;
         inj_pos_q  <= '0;
         inj_slot_q <= '0;
         ch_q       <= '0;
         en_q       <= 1'b0;
         reg_data_q <= '0;
         eoc_reg_q  <= 1'b0;
         eoc_inj_q  <= 1'b0;
      end else begin
         grp_q     <= grp_d;
         reg_idx_q <= reg_idx_d;
         reg_run_q <= reg_run_d;
         inj_pos_q <= inj_pos_d;
         en_q      <= conv_enable;
         if (tmr_start) begin
            ch_q       <= start_ch;
            inj_slot_q <= start_slot;
         end
         if (store_reg) reg_data_q <= res_word;
         eoc_reg_q <= set_eoc_reg | (eoc_reg_q & ~clr_eoc_reg);
         eoc_inj_q <= set_eoc_inj | (eoc_inj_q & ~clr_eoc_inj);
      end
   end

   for (genvar s = 0; s < INJ_SLOTS; s++) begin : g_inj_reg
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    slot_q <= '0;
         else if (store_inj && inj_slot_q == ILW'(s))   slot_q <= res_word;
      end
      assign inj_data[s*DATA_W +: DATA_W] = slot_q;
   end

   assign ch_sel   = ch_q;
   assign reg_data = reg_data_q;
   assign eoc_reg  = eoc_reg_q;
   assign eoc_inj  = eoc_inj_q;
   assign irq_reg  = eoc_reg_q & irq_reg_en;
   assign irq_inj  = eoc_inj_q & irq_inj_en;
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker
   import adcseq_pkg::*;
#(
   parameter int unsigned CH_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_enable,
   input logic [CH_W-1:0] ch_sel,
   input logic            smp_phase,
   input logic            cnv_phase,
   input logic            eoc_reg,
   input logic            eoc_inj
);
   localparam int unsigned RUN_W = $clog2(CONV_CYCLES) + 1;
   logic [RUN_W-1:0] cnv_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnv_run <= '0;
      else if (cnv_phase) cnv_run <= cnv_run + 1'b1;
      else                cnv_run <= '0;
   end

   a_r6_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_phase && cnv_phase));
   a_r6_conv_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_phase |-> (cnv_run < RUN_W'(CONV_CYCLES)));
   a_r6_conv_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_phase) |-> $past(smp_phase));
   a_r6_ch_moves_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_sel != $past(ch_sel)) |-> smp_phase);
   a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(conv_enable) |-> !(smp_phase || cnv_phase));
   a_r11_reg_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_reg) |-> $past(cnv_phase));
   a_r11_inj_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_inj) |-> $past(cnv_phase));
endmodule

bind adc_conv_sequencer adcseq_checker #(.CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_enable(conv_enable), .ch_sel(ch_sel),
   .smp_phase(smp_phase), .cnv_phase(cnv_phase), .eoc_reg(eoc_reg), .eoc_inj(eoc_inj));

// File: tb/adc_conv_sequencer_tb_top.sv
module adc_conv_sequencer_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic conv_enable = 0, scan_mode = 0, cont_mode = 0, align_left = 0;
   logic [63:0] reg_slot_ch = '0;
   logic [3:0]  reg_len = '0;
   logic [15:0] inj_slot_ch = '0;
   logic [1:0]  inj_len = '0;
   logic [47:0] smp_code = '0;
   logic reg_trig = 0, inj_trig = 0;
   logic [1:0] reg_trig_mode = 0, inj_trig_mode = 0;
   logic [11:0] adc_result;
   logic clr_eoc_reg = 0, clr_eoc_inj = 0, irq_reg_en = 1, irq_inj_en = 1;
   logic [3:0]  ch_sel;
   logic smp_phase, cnv_phase, eoc_reg, eoc_inj, irq_reg, irq_inj;
   logic [15:0] reg_data;
   logic [63:0] inj_data;

   always #4 clk = ~clk;   // 125 MHz

   // converter model: result depends only on the selected channel
   assign adc_result = {ch_sel, 4'hA, ~ch_sel};

   adc_conv_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .conv_enable(conv_enable), .scan_mode(scan_mode),
      .cont_mode(cont_mode), .align_left(align_left), .reg_slot_ch(reg_slot_ch),
      .reg_len(reg_len), .inj_slot_ch(inj_slot_ch), .inj_len(inj_len),
      .smp_code(smp_code), .reg_trig(reg_trig), .reg_trig_mode(reg_trig_mode),
      .inj_trig(inj_trig), .inj_trig_mode(inj_trig_mode), .adc_result(adc_result),
      .clr_eoc_reg(clr_eoc_reg), .clr_eoc_inj(clr_eoc_inj), .irq_reg_en(irq_reg_en),
      .irq_inj_en(irq_inj_en), .ch_sel(ch_sel), .smp_phase(smp_phase),
      .cnv_phase(cnv_phase), .reg_data(reg_data), .inj_data(inj_data),
      .eoc_reg(eoc_reg), .eoc_inj(eoc_inj), .irq_reg(irq_reg), .irq_inj(irq_inj));

   typedef struct { logic [3:0] ch; bit inj; int slot; bit left; int req; } exp_t;
   exp_t exp_q[$];
   int checks = 0, errors = 0, done_cnt = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] expect_word(input logic [3:0] ch, input bit left);
      logic [11:0] r = {ch, 4'hA, ~ch};
      return left ? {r, 4'h0} : {4'h0, r};
   endfunction

   task automatic push(input logic [3:0] ch, input bit inj, input int slot, input int req);
      exp_t e;
      e.ch = ch; e.inj = inj; e.slot = slot; e.left = align_left; e.req = req;
      exp_q.push_back(e);
   endtask

   // monitor: rebuilds each completed conversion and pops the scoreboard
   int smp_cnt = 0, cnv_cnt = 0;
   logic [3:0] cur_ch = '0;
   bit prev_smp = 0, chk_pend = 0;
   exp_t pend;
   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_pend) begin
            chk_pend = 0;
            if (pend.inj)
               check(inj_data[pend.slot*16 +: 16] == expect_word(pend.ch, pend.left),
                     "R10/R9", "injected data", inj_data[pend.slot*16 +: 16],
                     expect_word(pend.ch, pend.left));
            else
               check(reg_data == expect_word(pend.ch, pend.left), "R10/R9",
                     "regular data", reg_data, expect_word(pend.ch, pend.left));
         end
         if (smp_phase) begin
            if (!prev_smp || ch_sel != cur_ch) begin
               smp_cnt = 1; cnv_cnt = 0; cur_ch = ch_sel;
            end else smp_cnt++;
         end
         if (cnv_phase) begin
            cnv_cnt++;
            if (cnv_cnt == 12) begin
               done_cnt++;
               if (exp_q.size() == 0) begin
                  check(0, "R8", "unexpected conversion on channel", cur_ch, 0);
               end else begin
                  pend = exp_q.pop_front();
                  check(cur_ch == pend.ch, $sformatf("R%0d", pend.req), "channel order",
                        cur_ch, pend.ch);
                  check(smp_cnt == (3 << (cur_ch % 4)), "R6", "sample length",
                        smp_cnt, 3 << (cur_ch % 4));
                  chk_pend = 1;
               end
            end
         end
         prev_smp = smp_phase;
      end
   end

   task automatic wait_done(input string req);
      int n = 0, quiet = 0;
      while (!smp_phase && n < 100) begin @(negedge clk); n++; end
      check(smp_phase, req, "sequence started", smp_phase, 1);
      n = 0;
      while (quiet < 4 && n < 3000) begin
         @(negedge clk); n++;
         if (smp_phase || cnv_phase) quiet = 0; else quiet++;
      end
   endtask

   task automatic stay_quiet(input int cycles, input string req);
      bit busy = 0;
      repeat (cycles) begin @(negedge clk); if (smp_phase || cnv_phase) busy = 1; end
      check(!busy, req, "no conversion expected", busy, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int base;
      for (int c = 0; c < 16; c++) smp_code[c*3 +: 3] = 3'(c % 4);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ch_sel == 0 && !smp_phase && !cnv_phase, "R1", "strobes/channel",
            {ch_sel, smp_phase, cnv_phase}, 0);
      check(reg_data == 0 && inj_data == 0, "R1", "data registers", reg_data | inj_data, 0);
      check(!eoc_reg && !eoc_inj && !irq_reg && !irq_inj, "R1", "flags",
            {eoc_reg, eoc_inj, irq_reg, irq_inj}, 0);

      // R2 + R4: enable edge starts; scan off converts slot 0 only
      reg_slot_ch[3:0] = 4'd6; reg_slot_ch[7:4] = 4'd7; reg_len = 4'd1;
      push(4'd6, 0, 0, 4);
      conv_enable = 1;
      wait_done("R2");
      check(exp_q.size() == 0, "R4", "scan off single slot left items", exp_q.size(), 0);
      check(eoc_reg && irq_reg, "R11", "regular flag and irq", {eoc_reg, irq_reg}, 2'b11);
      clr_eoc_reg = 1; @(negedge clk); clr_eoc_reg = 0;
      check(!eoc_reg && !irq_reg, "R11", "regular flag clear", {eoc_reg, irq_reg}, 0);

      // R3 rising trigger, R4 scan order, R9 left alignment
      reg_slot_ch[15:0] = {4'd0, 4'd5, 4'd11, 4'd2}; reg_len = 4'd3;
      scan_mode = 1; align_left = 1; reg_trig_mode = 2'd1;
      push(4'd2, 0, 0, 4); push(4'd11, 0, 0, 4); push(4'd5, 0, 0, 4); push(4'd0, 0, 0, 4);
      reg_trig = 1;
      wait_done("R3");
      reg_trig = 0;
      stay_quiet(30, "R3");

      // R7 full injected list runs upward
      align_left = 0; inj_slot_ch = {4'd15, 4'd14, 4'd13, 4'd12};
      inj_len = 2'd3; inj_trig_mode = 2'd1;
      push(4'd12, 1, 0, 7); push(4'd13, 1, 1, 7); push(4'd14, 1, 2, 7); push(4'd15, 1, 3, 7);
      inj_trig = 1;
      wait_done("R7");
      inj_trig = 0;
      check(eoc_inj && irq_inj, "R11", "injected flag and irq", {eoc_inj, irq_inj}, 2'b11);
      clr_eoc_inj = 1; @(negedge clk); clr_eoc_inj = 0;

      // R7 short list runs downward; R8 second edge during the list ignored
      inj_len = 2'd1;
      push(4'd15, 1, 3, 7); push(4'd14, 1, 2, 7);
      base = done_cnt;
      inj_trig = 1; @(negedge clk); inj_trig = 0;
      while (!cnv_phase) @(negedge clk);
      inj_trig = 1;
      wait_done("R7");
      inj_trig = 0;
      check(done_cnt - base == 2, "R8", "injected conversions with extra edge",
            done_cnt - base, 2);
      irq_inj_en = 0; @(negedge clk);
      check(eoc_inj && !irq_inj, "R11", "irq masked", {eoc_inj, irq_inj}, 2'b10);
      irq_inj_en = 1;

      // R8 preemption mid-scan, R3 falling edge
      reg_slot_ch[11:0] = {4'd3, 4'd2, 4'd1}; reg_len = 4'd2;
      inj_slot_ch[15:12] = 4'd9; inj_len = 2'd0; reg_trig_mode = 2'd2;
      push(4'd1, 0, 0, 4); push(4'd9, 1, 3, 8); push(4'd2, 0, 0, 8); push(4'd3, 0, 0, 8);
      base = done_cnt;
      reg_trig = 1; @(negedge clk);
      reg_trig = 0;
      begin
         int n = 0;
         while (!(smp_phase && ch_sel == 4'd2) && n < 500) begin @(negedge clk); n++; end
      end
      inj_trig = 1;
      wait_done("R8");
      inj_trig = 0;
      check(done_cnt - base == 4, "R8", "conversions around preemption", done_cnt - base, 4);

      // R3 mode 0 blocks both triggers
      reg_trig_mode = 2'd0; inj_trig_mode = 2'd0;
      reg_trig = 1; inj_trig = 1;
      stay_quiet(30, "R3");

      // R5 continuous wrap with both-edge trigger, then R2 disable aborts
      reg_slot_ch[7:0] = {4'd5, 4'd4}; reg_len = 4'd1; cont_mode = 1; reg_trig_mode = 2'd3;
      push(4'd4, 0, 0, 5); push(4'd5, 0, 0, 5); push(4'd4, 0, 0, 5); push(4'd5, 0, 0, 5);
      base = done_cnt;
      reg_trig = 0;
      begin
         int n = 0;
         while (done_cnt < base + 4 && n < 2000) begin @(negedge clk); n++; end
      end
      check(done_cnt - base == 4, "R5", "wrapped conversions", done_cnt - base, 4);
      conv_enable = 0;
      @(negedge clk);
      check(!smp_phase && !cnv_phase, "R2", "abort on disable", {smp_phase, cnv_phase}, 0);
      stay_quiet(20, "R2");
      check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);

      // R2 triggers ignored while disabled
      cont_mode = 0; reg_trig_mode = 2'd1; inj_trig_mode = 2'd1;
      reg_trig = 0; inj_trig = 0; @(negedge clk);
      reg_trig = 1; inj_trig = 1;
      stay_quiet(30, "R2");
      finish_run();
   end
endmodule